// File: doc/BRIEF.md
# Cache Block-Cause Tracker

This block records the reasons a cache controller is currently turning work away and turns them into the port-level signals that the rest of the controller acts on. It keeps three cause vectors of four bits each. The access vector feeds the CPU-side port. The snoop vector feeds the memory-side port. The bus-request vector holds the reasons the controller wants the memory bus. Set and clear strobes each carry a two-bit cause index. One shared clear strobe removes a cause from both the access vector and the snoop vector.

Port block and unblock events are one-cycle pulses. They fire only when a vector goes from empty to non-empty or from non-empty to empty. A bus-request launch pulse fires when the request vector leaves the empty state, unless the port is waiting on a retry. Per-cause statistics record how many times each cause opened an access block and how many cycles blocks lasted. Each block's duration is charged to the cause whose removal ended it. All outputs are registered: a strobe sampled at a clock edge shows on the outputs just after that edge.

Top module: `cache_block_tracker`

## Requirements
- R1: An access set strobe with cause c sets bit c of `acc_vec`. Cause 0 is no free miss entry, 1 is no free target slot, 2 is no free writeback buffer and 3 is coherence. `cpu_blocked` is high exactly when `acc_vec` is nonzero.
- R2: Setting a cause that is already set leaves every vector, event output and counter unchanged.
- R3: `cpu_block_evt` pulses for one cycle only when `acc_vec` goes from zero to nonzero. `cpu_unblock_evt` pulses only when it goes from nonzero to zero.
- R4: A clear strobe with cause c clears bit c of both `acc_vec` and `snp_vec`.
- R5: A snoop set strobe sets bit c of `snp_vec`. `mem_blocked` equals (`snp_vec` != 0). `mem_block_evt` and `mem_unblock_evt` pulse only on the zero-to-nonzero and nonzero-to-zero transitions of `snp_vec`.
- R6: When a set and a clear name the same cause in the same cycle, the clear wins in every vector.
- R7: When `acc_vec` goes from zero to nonzero, the block counter of the cause being set increments. The counter for cause i sits at bits [i*CNT_W +: CNT_W] of `blk_count`.
- R8: When `acc_vec` returns to zero, the cycle counter of the cause cleared in that cycle increases by the number of cycles `acc_vec` was nonzero. The counter for cause i sits at bits [i*CYC_W +: CYC_W] of `blk_cycles`.
- R9: Block counters and cycle counters saturate at all ones and never wrap.
- R10: A request set strobe sets bit c of `req_vec`: cause 0 is miss handling, 1 writeback, 2 coherence, 3 prefetch. A request clear strobe clears bit c. `req_launch` pulses for one cycle only when `req_vec` goes from zero to nonzero while `retry_wait` is low in the strobe cycle.
- R11: A synchronous active-high reset clears all vectors, events, counters and the latched block start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_set_vld | input | 1 | Access-path set strobe |
| acc_set_cause | input | 2 | Cause index for the access set |
| snp_set_vld | input | 1 | Snoop-path set strobe |
| snp_set_cause | input | 2 | Cause index for the snoop set |
| clr_vld | input | 1 | Clear strobe for both access and snoop vectors |
| clr_cause | input | 2 | Cause index for the clear |
| req_set_vld | input | 1 | Bus-request set strobe |
| req_set_cause | input | 2 | Cause index for the request set |
| req_clr_vld | input | 1 | Bus-request clear strobe |
| req_clr_cause | input | 2 | Cause index for the request clear |
| retry_wait | input | 1 | Port waiting on a retry; suppresses launch |
| acc_vec | output | 4 | Access cause vector |
| snp_vec | output | 4 | Snoop cause vector |
| req_vec | output | 4 | Bus-request cause vector |
| cpu_blocked | output | 1 | Access path blocked |
| cpu_block_evt | output | 1 | Pulse: CPU-side port becomes blocked |
| cpu_unblock_evt | output | 1 | Pulse: CPU-side port becomes free |
| mem_blocked | output | 1 | Snoop path blocked |
| mem_block_evt | output | 1 | Pulse: memory-side port becomes blocked |
| mem_unblock_evt | output | 1 | Pulse: memory-side port becomes free |
| req_launch | output | 1 | Pulse: launch a bus-request event |
| blk_count | output | 32 | Per-cause block counts, 8 bits each |
| blk_cycles | output | 48 | Per-cause blocked-cycle totals, 12 bits each |

## Verification
The bench repeats a set on a cause that is already set. A design that re-pulsed the port or counted the block again would show a spurious event or a wrong count. It opens a block with one cause and closes it with another. This shows whether blocked cycles are charged to the releasing cause, which a design keyed on the opening cause would get wrong. Set and clear on the same cause in one cycle catch a design where the set wins. A clear while only the snoop vector holds the cause catches a clear that touches one path only. A request set during `retry_wait` must give no launch. Long runs of blocks and one very long block push both counter kinds past full scale, where a wrapping counter would fall back to small values.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
    localparam int N_CAUSE     = 4;
    localparam int CAUSE_W     = $clog2(N_CAUSE);
    localparam int BLK_CNT_W   = 8;
    localparam int BLK_CYC_W   = 12;
    localparam int BLK_TICK_W  = 16;

    // access / snoop cause bit positions
    localparam int BLK_NO_MISS_ENTRY = 0;
    localparam int BLK_NO_TARGET     = 1;
    localparam int BLK_NO_WB_BUF     = 2;
    localparam int BLK_COHERENCE     = 3;

    // bus-request cause bit positions
    localparam int REQ_MISS      = 0;
    localparam int REQ_WRITEBACK = 1;
    localparam int REQ_COHERENCE = 2;
    localparam int REQ_PREFETCH  = 3;
endpackage

// File: rtl/cbt_cause_vec.sv
module cbt_cause_vec #(
    parameter int W = 4,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          set_vld,
    input  logic [IW-1:0] set_idx,
    input  logic          clr_vld,
    input  logic [IW-1:0] clr_idx,
    output logic [W-1:0]  vec_o,
    output logic          rise_o,
    output logic          fall_o,
    output logic          rise_now_o,
    output logic          fall_now_o
);
    typedef struct packed {
        logic [W-1:0] vec;
        logic         rise;
        logic         fall;
    } st_t;

    st_t st_d, st_q;
    logic [W-1:0] set_m, clr_m, nxt;

    always_comb begin
        set_m      = set_vld ? (W'(1) << set_idx) : '0;
        clr_m      = clr_vld ? (W'(1) << clr_idx) : '0;
        nxt        = (st_q.vec | set_m) & ~clr_m;   // clear dominates
        rise_now_o = (st_q.vec == '0) && (nxt != '0);
        fall_now_o = (st_q.vec != '0) && (nxt == '0);
        st_d       = st_q;
        st_d.vec   = nxt;
        st_d.rise  = rise_now_o;
        st_d.fall  = fall_now_o;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign vec_o  = st_q.vec;
    assign rise_o = st_q.rise;
    assign fall_o = st_q.fall;

    AST_RISE_FROM_EMPTY: assert property (@(posedge clk) disable iff (rst)
        st_q.rise |-> ($past(st_q.vec) == '0 && st_q.vec != '0)); // R3
    AST_FALL_TO_EMPTY: assert property (@(posedge clk) disable iff (rst)
        st_q.fall |-> ($past(st_q.vec) != '0 && st_q.vec == '0)); // R3
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        $past(clr_vld) |-> !st_q.vec[$past(clr_idx)]); // R6
    AST_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
        ($past(set_vld) && !($past(clr_vld) && $past(clr_idx) == $past(set_idx)))
        |-> st_q.vec[$past(set_idx)]); // R1
endmodule

// File: rtl/cbt_blk_stats.sv
module cbt_blk_stats #(
    parameter int N      = 4,
    parameter int CNT_W  = 8,
    parameter int CYC_W  = 12,
    parameter int TICK_W = 16,
    localparam int IW    = (N > 1) ? $clog2(N) : 1,
    localparam int SUM_W = ((CYC_W > TICK_W) ? CYC_W : TICK_W) + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_evt,
    input  logic [IW-1:0]      start_idx,
    input  logic               end_evt,
    input  logic [IW-1:0]      end_idx,
    output logic [N*CNT_W-1:0] cnt_flat,
    output logic [N*CYC_W-1:0] cyc_flat
);
    typedef struct packed {
        logic [TICK_W-1:0]         tick;
        logic [TICK_W-1:0]         start;
        logic [N-1:0][CNT_W-1:0]   cnt;
        logic [N-1:0][CYC_W-1:0]   cyc;
    } st_t;

    localparam logic [SUM_W-1:0] CYC_MAX = SUM_W'({CYC_W{1'b1}});

    st_t st_d, st_q;
    logic [TICK_W-1:0] elapsed;
    logic [SUM_W-1:0]  sum;

    always_comb begin
        st_d      = st_q;
        st_d.tick = st_q.tick + 1'b1;
        elapsed   = st_q.tick - st_q.start;
        sum       = SUM_W'(st_q.cyc[end_idx]) + SUM_W'(elapsed);
        if (start_evt) begin
            st_d.start = st_q.tick;
            if (st_q.cnt[start_idx] != '1)
                st_d.cnt[start_idx] = st_q.cnt[start_idx] + 1'b1;
        end
        if (end_evt) begin
            st_d.cyc[end_idx] = (sum > CYC_MAX) ? '1 : sum[CYC_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cnt_flat = st_q.cnt;
    assign cyc_flat = st_q.cyc;

    for (genvar i = 0; i < N; i++) begin : g_chk
        AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(st_q.cnt[i]) != '0) |-> (st_q.cnt[i] >= $past(st_q.cnt[i]))); // R9
        AST_CYC_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(st_q.cyc[i]) != '0) |-> (st_q.cyc[i] >= $past(st_q.cyc[i]))); // R9
    end
endmodule

// File: rtl/cache_block_tracker.sv
module cache_block_tracker
    import cbt_pkg::*;
#(
    parameter int N      = N_CAUSE,
    parameter int CNT_W  = BLK_CNT_W,
    parameter int CYC_W  = BLK_CYC_W,
    parameter int TICK_W = BLK_TICK_W,
    localparam int IW    = (N > 1) ? $clog2(N) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               acc_set_vld,
    input  logic [IW-1:0]      acc_set_cause,
    input  logic               snp_set_vld,
    input  logic [IW-1:0]      snp_set_cause,
    input  logic               clr_vld,
    input  logic [IW-1:0]      clr_cause,
    input  logic               req_set_vld,
    input  logic [IW-1:0]      req_set_cause,
    input  logic               req_clr_vld,
    input  logic [IW-1:0]      req_clr_cause,
    input  logic               retry_wait,
    output logic [N-1:0]       acc_vec,
    output logic [N-1:0]       snp_vec,
    output logic [N-1:0]       req_vec,
    output logic               cpu_blocked,
    output logic               cpu_block_evt,
    output logic               cpu_unblock_evt,
    output logic               mem_blocked,
    output logic               mem_block_evt,
    output logic               mem_unblock_evt,
    output logic               req_launch,
    output logic [N*CNT_W-1:0] blk_count,
    output logic [N*CYC_W-1:0] blk_cycles
);
    typedef struct packed {
        logic launch;
    } top_st_t;

    top_st_t st_d, st_q;
    logic acc_rise_now, acc_fall_now;
    logic snp_rise_now, snp_fall_now;
    logic req_rise_now, req_fall_now;
    logic req_rise_q, req_fall_q;

    cbt_cause_vec #(.W(N)) u_acc (
        .clk(clk), .rst(rst),
        .set_vld(acc_set_vld), .set_idx(acc_set_cause),
        .clr_vld(clr_vld), .clr_idx(clr_cause),
        .vec_o(acc_vec), .rise_o(cpu_block_evt), .fall_o(cpu_unblock_evt),
        .rise_now_o(acc_rise_now), .fall_now_o(acc_fall_now)
    );

    cbt_cause_vec #(.W(N)) u_snp (
        .clk(clk), .rst(rst),
        .set_vld(snp_set_vld), .set_idx(snp_set_cause),
        .clr_vld(clr_vld), .clr_idx(clr_cause),
        .vec_o(snp_vec), .rise_o(mem_block_evt), .fall_o(mem_unblock_evt),
        .rise_now_o(snp_rise_now), .fall_now_o(snp_fall_now)
    );

    cbt_cause_vec #(.W(N)) u_req (
        .clk(clk), .rst(rst),
        .set_vld(req_set_vld), .set_idx(req_set_cause),
        .clr_vld(req_clr_vld), .clr_idx(req_clr_cause),
        .vec_o(req_vec), .rise_o(req_rise_q), .fall_o(req_fall_q),
        .rise_now_o(req_rise_now), .fall_now_o(req_fall_now)
    );

    cbt_blk_stats #(.N(N), .CNT_W(CNT_W), .CYC_W(CYC_W), .TICK_W(TICK_W)) u_stats (
        .clk(clk), .rst(rst),
        .start_evt(acc_rise_now), .start_idx(acc_set_cause),
        .end_evt(acc_fall_now), .end_idx(clr_cause),
        .cnt_flat(blk_count), .cyc_flat(blk_cycles)
    );

    always_comb begin
        st_d        = st_q;
        st_d.launch = req_rise_now && !retry_wait;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign req_launch  = st_q.launch;
    assign cpu_blocked = (acc_vec != '0);
    assign mem_blocked = (snp_vec != '0);

    AST_LAUNCH_NOT_IN_RETRY: assert property (@(posedge clk) disable iff (rst)
        req_launch |-> !$past(retry_wait)); // R10
    AST_LAUNCH_ON_FIRST: assert property (@(posedge clk) disable iff (rst)
        req_launch |-> req_rise_q); // R10
    AST_LAUNCH_NOT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        req_fall_q |-> !req_launch); // R10
    AST_REQ_EMPTY_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        req_fall_now |=> (req_vec == '0)); // R10
    AST_CPU_EVT_LEVEL: assert property (@(posedge clk) disable iff (rst)
        cpu_block_evt |-> cpu_blocked); // R3
    AST_CPU_EDGES_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(cpu_block_evt && cpu_unblock_evt)); // R3
    AST_MEM_RISE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        snp_rise_now |=> mem_blocked); // R5
    AST_MEM_FALL_FREES: assert property (@(posedge clk) disable iff (rst)
        snp_fall_now |=> !mem_blocked); // R5
    AST_CLR_BOTH_PATHS: assert property (@(posedge clk) disable iff (rst)
        $past(clr_vld) |-> (!acc_vec[$past(clr_cause)] && !snp_vec[$past(clr_cause)])); // R4
endmodule

// File: tb/tb_cache_block_tracker.sv
`timescale 1ns/1ps
module tb_cache_block_tracker;
    localparam int NC = 4;
    localparam int CNT_MAX = 255;
    localparam int CYC_MAX = 4095;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic acc_set_vld = 0, snp_set_vld = 0, clr_vld = 0, req_set_vld = 0, req_clr_vld = 0;
    logic [1:0] acc_set_cause = 0, snp_set_cause = 0, clr_cause = 0, req_set_cause = 0, req_clr_cause = 0;
    logic retry_wait = 0;
    logic [3:0] acc_vec, snp_vec, req_vec;
    logic cpu_blocked, cpu_block_evt, cpu_unblock_evt;
    logic mem_blocked, mem_block_evt, mem_unblock_evt, req_launch;
    logic [31:0] blk_count;
    logic [47:0] blk_cycles;

    always #4 clk = ~clk;

    cache_block_tracker dut (
        .clk(clk), .rst(rst),
        .acc_set_vld(acc_set_vld), .acc_set_cause(acc_set_cause),
        .snp_set_vld(snp_set_vld), .snp_set_cause(snp_set_cause),
        .clr_vld(clr_vld), .clr_cause(clr_cause),
        .req_set_vld(req_set_vld), .req_set_cause(req_set_cause),
        .req_clr_vld(req_clr_vld), .req_clr_cause(req_clr_cause),
        .retry_wait(retry_wait),
        .acc_vec(acc_vec), .snp_vec(snp_vec), .req_vec(req_vec),
        .cpu_blocked(cpu_blocked), .cpu_block_evt(cpu_block_evt), .cpu_unblock_evt(cpu_unblock_evt),
        .mem_blocked(mem_blocked), .mem_block_evt(mem_block_evt), .mem_unblock_evt(mem_unblock_evt),
        .req_launch(req_launch), .blk_count(blk_count), .blk_cycles(blk_cycles)
    );

    int n_cmp = 0, n_bad = 0;
    bit started = 0;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural reference
    int m_acc, m_snp, m_req, m_run;
    int m_cnt[NC];
    int m_cyc[NC];
    bit m_cb, m_cu, m_mb, m_mu, m_ln;

    always @(posedge clk) begin
        int old, nw, sm, cm;
        if (rst) begin
            m_acc = 0; m_snp = 0; m_req = 0; m_run = 0;
            m_cb = 0; m_cu = 0; m_mb = 0; m_mu = 0; m_ln = 0;
            for (int i = 0; i < NC; i++) begin m_cnt[i] = 0; m_cyc[i] = 0; end
        end else begin
            cm = clr_vld ? (1 << clr_cause) : 0;
            old = m_acc;
            sm = acc_set_vld ? (1 << acc_set_cause) : 0;
            nw = (old | sm) & ~cm & 15;
            if (old != 0) m_run++;
            m_cb = (old == 0) && (nw != 0);
            m_cu = (old != 0) && (nw == 0);
            if (m_cb) begin
                if (m_cnt[acc_set_cause] < CNT_MAX) m_cnt[acc_set_cause]++;
                m_run = 0;
            end
            if (m_cu) begin
                m_cyc[clr_cause] = m_cyc[clr_cause] + m_run;
                if (m_cyc[clr_cause] > CYC_MAX) m_cyc[clr_cause] = CYC_MAX;
                m_run = 0;
            end
            m_acc = nw;
            old = m_snp;
            sm = snp_set_vld ? (1 << snp_set_cause) : 0;
            nw = (old | sm) & ~cm & 15;
            m_mb = (old == 0) && (nw != 0);
            m_mu = (old != 0) && (nw == 0);
            m_snp = nw;
            old = m_req;
            sm = req_set_vld ? (1 << req_set_cause) : 0;
            nw = (old | sm) & ~(req_clr_vld ? (1 << req_clr_cause) : 0) & 15;
            m_ln = (old == 0) && (nw != 0) && !retry_wait;
            m_req = nw;
        end
        started = 1;
    end

    always @(negedge clk) begin
        if (started) begin
            check("R1", "acc_vec", acc_vec, m_acc);
            check("R1", "cpu_blocked", cpu_blocked, m_acc != 0);
            check("R3", "cpu_block_evt", cpu_block_evt, m_cb);
            check("R3", "cpu_unblock_evt", cpu_unblock_evt, m_cu);
            check("R5", "snp_vec", snp_vec, m_snp);
            check("R5", "mem_blocked", mem_blocked, m_snp != 0);
            check("R5", "mem_block_evt", mem_block_evt, m_mb);
            check("R5", "mem_unblock_evt", mem_unblock_evt, m_mu);
            check("R10", "req_vec", req_vec, m_req);
            check("R10", "req_launch", req_launch, m_ln);
            for (int i = 0; i < NC; i++) begin
                check("R7", "blk_count", blk_count[i*8 +: 8], m_cnt[i]);
                check("R8", "blk_cycles", blk_cycles[i*12 +: 12], m_cyc[i]);
            end
        end
    end

    task automatic op(input bit as, input int ac, input bit ss, input int sc,
                      input bit cl, input int cc, input bit rs, input int rc,
                      input bit rcl, input int rcc);
        acc_set_vld = as; acc_set_cause = 2'(ac);
        snp_set_vld = ss; snp_set_cause = 2'(sc);
        clr_vld = cl; clr_cause = 2'(cc);
        req_set_vld = rs; req_set_cause = 2'(rc);
        req_clr_vld = rcl; req_clr_cause = 2'(rcc);
        @(negedge clk);
        acc_set_vld = 0; snp_set_vld = 0; clr_vld = 0; req_set_vld = 0; req_clr_vld = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        rst = 0;
        check("R11", "acc_vec after reset", acc_vec, 0);
        check("R11", "blk_count after reset", int'(blk_count), 0);

        // R1/R3/R7: open a block with cause 0
        op(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        check("R3", "block pulse on first set", cpu_block_evt, 1);
        // R2: same cause again
        op(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        check("R2", "no pulse on repeat set", cpu_block_evt, 0);
        check("R2", "count unchanged on repeat", blk_count[7:0], 1);
        // second cause while blocked: no count for it
        op(1, 2, 0, 0, 0, 0, 0, 0, 0, 0);
        check("R7", "no count when already blocked", blk_count[23:16], 0);
        idle(10);
        op(0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
        check("R3", "still blocked after partial clear", cpu_blocked, 1);
        idle(4);
        op(0, 0, 0, 0, 1, 2, 0, 0, 0, 0);
        check("R8", "cycles charged to releasing cause", blk_cycles[35:24] != 0, 1);
        check("R8", "opening cause not charged", blk_cycles[11:0], 0);

        // R4/R5: snoop path and shared clear
        op(0, 0, 1, 1, 0, 0, 0, 0, 0, 0);
        check("R5", "mem block pulse", mem_block_evt, 1);
        op(1, 1, 1, 3, 0, 0, 0, 0, 0, 0);
        op(0, 0, 0, 0, 1, 1, 0, 0, 0, 0);
        check("R4", "clear hits access", acc_vec, 0);
        check("R4", "clear hits snoop", snp_vec, 8);
        op(0, 0, 0, 0, 1, 3, 0, 0, 0, 0);
        check("R5", "mem unblock pulse", mem_unblock_evt, 1);

        // R6: set and clear of one cause together
        op(1, 3, 1, 3, 1, 3, 0, 0, 0, 0);
        check("R6", "clear wins access", acc_vec, 0);
        check("R6", "clear wins snoop", snp_vec, 0);
        op(0, 0, 0, 0, 0, 0, 1, 2, 1, 2);
        check("R6", "clear wins request", req_vec, 0);

        // R10: request launch rules
        op(0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
        check("R10", "launch on first request", req_launch, 1);
        op(0, 0, 0, 0, 0, 0, 1, 1, 0, 0);
        check("R10", "no launch when pending", req_launch, 0);
        op(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
        op(0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
        retry_wait = 1;
        op(0, 0, 0, 0, 0, 0, 1, 3, 0, 0);
        retry_wait = 0;
        check("R10", "no launch during retry wait", req_launch, 0);
        op(0, 0, 0, 0, 0, 0, 0, 0, 1, 3);
        op(0, 0, 0, 0, 0, 0, 1, 2, 0, 0);
        check("R10", "launch after retry ends", req_launch, 1);

        // R9: count saturation
        for (int k = 0; k < 260; k++) begin
            op(1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
            op(0, 0, 0, 0, 1, 1, 0, 0, 0, 0);
        end
        check("R9", "block count saturates", blk_count[15:8], CNT_MAX);
        // R9: cycle saturation
        op(1, 3, 0, 0, 0, 0, 0, 0, 0, 0);
        idle(4200);
        op(0, 0, 0, 0, 1, 3, 0, 0, 0, 0);
        check("R9", "cycle count saturates", blk_cycles[47:36], CYC_MAX);

        // R11: reset from a busy state
        op(1, 2, 1, 2, 0, 0, 1, 1, 0, 0);
        rst = 1;
        idle(2);
        rst = 0;
        check("R11", "access cleared", acc_vec, 0);
        check("R11", "snoop cleared", snp_vec, 0);
        check("R11", "request cleared", req_vec, 0);
        check("R11", "cycles cleared", int'(blk_cycles[47:36]), 0);
        idle(2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule